// File: doc/BRIEF.md
# Dual-Socket Posted Write Buffer

This block lets a host finish writes to card sockets without waiting for the slower card side. Each host write names a target socket and carries an address, a 16-bit data word, two byte-enable bits and a flag for memory or I/O space. The write goes into that socket's own four-entry buffer, and the host sees a ready indication at once. The only time ready drops and the host gets wait states is when the addressed buffer is full and nothing leaves it in that cycle.

Each socket drains its buffer in arrival order through a request/acknowledge pair. The oldest entry sits on the card-side outputs, and request stays high while the buffer holds anything. One entry leaves on every clock edge where both request and acknowledge are high. Each socket also reports a flag that is high while its buffer is empty. Configuration logic uses this flag to hold back register changes until all earlier posted writes have reached the card.

The reset input is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pwb_buffer_top`

## Requirements
- R1: While reset is applied and after it is released, both buffers are empty: `empty_o` is all ones, `crd_req_o` is all zeros and `hst_rdy_o` is high.
- R2: A write is accepted on a rising edge where `hst_wr_i` and `hst_rdy_o` are both high. It enters only the buffer selected by `hst_sel_i` (0 selects socket 0, 1 selects socket 1).
- R3: If the selected buffer holds fewer than four entries, `hst_rdy_o` is high in the same cycle as `hst_wr_i`, so the write takes zero wait states.
- R4: If the selected buffer holds four entries and is not draining in that cycle, `hst_rdy_o` is low and the write is not taken. Ready returns high in the first cycle in which that socket's acknowledge drains an entry.
- R5: A write to a full buffer in a cycle where the same buffer drains (request and acknowledge both high) is accepted with no wait state.
- R6: Entries leave each buffer in the order they were accepted. Address, data, byte enables and the I/O flag are unchanged on the way through.
- R7: `crd_req_o[s]` is high exactly while buffer s is not empty. While request is high and acknowledge is low, the presented entry does not change.
- R8: `empty_o[s]` is high exactly when buffer s holds no entries. It rises in the cycle after the last entry is acknowledged.
- R9: The two buffers are independent. A full socket 1 buffer does not stall writes to socket 0, and the reverse is also true.
- R10: Each buffer holds at most four entries. Four writes in a row with no drain take zero wait states, and the fifth stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| hst_wr_i | input | 1 | Host write strobe, held until ready |
| hst_sel_i | input | 1 | Target socket of the write |
| hst_addr_i | input | 16 | Write address |
| hst_data_i | input | 16 | Write data |
| hst_be_i | input | 2 | Byte enables (bit 0 low byte, bit 1 high byte) |
| hst_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| hst_rdy_o | output | 1 | Low adds a wait state |
| crd_req_o | output | 2 | Per-socket entry-valid request |
| crd_ack_i | input | 2 | Per-socket acknowledge, pops the head entry |
| crd_addr_o | output | 32 | Head address, socket s in bits [16s+15:16s] |
| crd_data_o | output | 32 | Head data, socket s in bits [16s+15:16s] |
| crd_be_o | output | 4 | Head byte enables, socket s in bits [2s+1:2s] |
| crd_io_o | output | 2 | Head I/O flag per socket |
| empty_o | output | 2 | Per-socket buffer-empty flag |

## Verification
The hardest case to reach from the ports is a write that arrives at a full buffer in exactly the cycle an entry drains. Here ready must stay high, and push and pop must happen together. The bench fills socket 0 with acknowledges held off. It then raises that socket's acknowledge in the same cycle the fifth write is presented, and expects zero wait states. A second version raises acknowledge only after a known number of stalled cycles, which fixes the exact wait count. Randomised acknowledges on both sockets, with interleaved writes, then check ordering and head stability against a scoreboard.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int BEN_W  = DATA_W / 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BEN_W-1:0]  ben;
    logic              is_io;
  } pwb_entry_t;

  localparam int ENTRY_W = $bits(pwb_entry_t);
endpackage

// File: rtl/pwb_rst_sync.sv
module pwb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwb_ring.sv
module pwb_ring #(
  parameter int DEPTH = 4,
  parameter int EW    = 35
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          push_i,
  input  logic [EW-1:0] din_i,
  input  logic          pop_i,
  output logic [EW-1:0] dout_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d;
  logic [PW-1:0] rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  // next state
  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = bump(wr_q);
    if (pop_i)  rd_d = bump(rd_q);
    cnt_d = cnt_q + CW'(push_i) - CW'(pop_i);
  end

  // pointer and count registers
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage, one clock enable per slot, no reset
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_en;
    assign slot_en = push_i && (wr_q == PW'(i));
    always_ff @(posedge clk_i) begin
      if (slot_en) mem_q[i] <= din_i;
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/pwb_host_gate.sv
module pwb_host_gate #(
  parameter int NUM_SOCK = 2,
  parameter int SEL_W    = 1
) (
  input  logic                wr_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_SOCK-1:0] full_i,
  input  logic [NUM_SOCK-1:0] pop_i,
  output logic [NUM_SOCK-1:0] push_o,
  output logic                rdy_o
);
  always_comb begin
    rdy_o  = 1'b1;
    push_o = '0;
    for (int s = 0; s < NUM_SOCK; s++) begin
      if (sel_i == SEL_W'(s)) begin
        rdy_o     = !full_i[s] || pop_i[s];
        push_o[s] = wr_i && rdy_o;
      end
    end
  end
endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
  import pwb_pkg::*;
(
  input  logic              empty_i,
  input  logic              ack_i,
  input  pwb_entry_t        head_i,
  output logic              req_o,
  output logic              pop_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [BEN_W-1:0]  be_o,
  output logic              io_o
);
  assign req_o  = !empty_i;
  assign pop_o  = req_o && ack_i;
  assign addr_o = head_i.addr;
  assign data_o = head_i.data;
  assign be_o   = head_i.ben;
  assign io_o   = head_i.is_io;
endmodule

// File: rtl/pwb_buffer_top.sv
module pwb_buffer_top
  import pwb_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  parameter int DEPTH    = 4,
  localparam int SEL_W   = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_n_i,
  input  logic                       hst_wr_i,
  input  logic [SEL_W-1:0]           hst_sel_i,
  input  logic [ADDR_W-1:0]          hst_addr_i,
  input  logic [DATA_W-1:0]          hst_data_i,
  input  logic [BEN_W-1:0]           hst_be_i,
  input  logic                       hst_io_i,
  output logic                       hst_rdy_o,
  output logic [NUM_SOCK-1:0]        crd_req_o,
  input  logic [NUM_SOCK-1:0]        crd_ack_i,
  output logic [NUM_SOCK*ADDR_W-1:0] crd_addr_o,
  output logic [NUM_SOCK*DATA_W-1:0] crd_data_o,
  output logic [NUM_SOCK*BEN_W-1:0]  crd_be_o,
  output logic [NUM_SOCK-1:0]        crd_io_o,
  output logic [NUM_SOCK-1:0]        empty_o
);
  logic                rst_q_n;
  logic [NUM_SOCK-1:0] push_w, pop_w, full_w, empty_w;
  pwb_entry_t          in_entry;

  pwb_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_q_n (rst_q_n)
  );

  assign in_entry = '{addr: hst_addr_i, data: hst_data_i, ben: hst_be_i, is_io: hst_io_i};

  pwb_host_gate #(.NUM_SOCK(NUM_SOCK), .SEL_W(SEL_W)) gate_i (
    .wr_i   (hst_wr_i),
    .sel_i  (hst_sel_i),
    .full_i (full_w),
    .pop_i  (pop_w),
    .push_o (push_w),
    .rdy_o  (hst_rdy_o)
  );

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_sock
    logic [ENTRY_W-1:0] head_raw;
    pwb_entry_t         head;

    pwb_ring #(.DEPTH(DEPTH), .EW(ENTRY_W)) ring_i (
      .clk_i   (clk_i),
      .rst_n_i (rst_q_n),
      .push_i  (push_w[s]),
      .din_i   (in_entry),
      .pop_i   (pop_w[s]),
      .dout_o  (head_raw),
      .full_o  (full_w[s]),
      .empty_o (empty_w[s])
    );

    assign head = pwb_entry_t'(head_raw);

    pwb_drain drain_i (
      .empty_i (empty_w[s]),
      .ack_i   (crd_ack_i[s]),
      .head_i  (head),
      .req_o   (crd_req_o[s]),
      .pop_o   (pop_w[s]),
      .addr_o  (crd_addr_o[s*ADDR_W +: ADDR_W]),
      .data_o  (crd_data_o[s*DATA_W +: DATA_W]),
      .be_o    (crd_be_o[s*BEN_W +: BEN_W]),
      .io_o    (crd_io_o[s])
    );
  end

  assign empty_o = empty_w;
endmodule

// File: rtl/pwb_buffer_chk.sv
module pwb_buffer_chk
  import pwb_pkg::*;
#(
  parameter int NUM_SOCK = 2,
  parameter int DEPTH    = 4,
  parameter int SEL_W    = 1
) (
  input logic                       clk_i,
  input logic                       rst_q_n,
  input logic                       hst_wr_i,
  input logic [SEL_W-1:0]           hst_sel_i,
  input logic                       hst_rdy_o,
  input logic [NUM_SOCK-1:0]        crd_req_o,
  input logic [NUM_SOCK-1:0]        crd_ack_i,
  input logic [NUM_SOCK*ADDR_W-1:0] crd_addr_o,
  input logic [NUM_SOCK*DATA_W-1:0] crd_data_o,
  input logic [NUM_SOCK*BEN_W-1:0]  crd_be_o,
  input logic [NUM_SOCK-1:0]        crd_io_o,
  input logic [NUM_SOCK-1:0]        empty_o
);
  localparam int CW = $clog2(DEPTH + 1);

  for (genvar s = 0; s < NUM_SOCK; s++) begin : g_chk
    logic [CW-1:0] shd_q;
    logic          in_w, out_w, tgt_w;

    assign tgt_w = (hst_sel_i == SEL_W'(s));
    assign in_w  = hst_wr_i && hst_rdy_o && tgt_w;
    assign out_w = crd_req_o[s] && crd_ack_i[s];

    always_ff @(posedge clk_i or negedge rst_q_n) begin
      if (!rst_q_n) shd_q <= '0;
      else          shd_q <= shd_q + CW'(in_w) - CW'(out_w);
    end

    // R10
    cap_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      shd_q <= CW'(DEPTH));

    // R3
    zero_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (hst_wr_i && tgt_w && shd_q < CW'(DEPTH)) |-> hst_rdy_o);

    // R4
    stall_full_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (hst_wr_i && tgt_w && !hst_rdy_o) |-> (shd_q == CW'(DEPTH) && !out_w));

    // R5
    pass_through_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (hst_wr_i && tgt_w && out_w) |-> hst_rdy_o);

    // R8
    empty_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      empty_o[s] == (shd_q == '0));

    // R7
    head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_q_n)
      (crd_req_o[s] && !crd_ack_i[s]) |=>
        (crd_req_o[s] && $stable(crd_addr_o[s*ADDR_W +: ADDR_W])
         && $stable(crd_data_o[s*DATA_W +: DATA_W])
         && $stable(crd_be_o[s*BEN_W +: BEN_W]) && $stable(crd_io_o[s])));
  end
endmodule

bind pwb_buffer_top pwb_buffer_chk #(
  .NUM_SOCK (NUM_SOCK),
  .DEPTH    (DEPTH),
  .SEL_W    (SEL_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_q_n    (rst_q_n),
  .hst_wr_i   (hst_wr_i),
  .hst_sel_i  (hst_sel_i),
  .hst_rdy_o  (hst_rdy_o),
  .crd_req_o  (crd_req_o),
  .crd_ack_i  (crd_ack_i),
  .crd_addr_o (crd_addr_o),
  .crd_data_o (crd_data_o),
  .crd_be_o   (crd_be_o),
  .crd_io_o   (crd_io_o),
  .empty_o    (empty_o)
);

// File: tb/pwb_buffer_top_tb_top.sv
module pwb_buffer_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam int NS = 2;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [BW-1:0] b;
    logic          i;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic           hst_wr = 1'b0;
  logic           hst_sel = 1'b0;
  logic [AW-1:0]  hst_addr = '0;
  logic [DW-1:0]  hst_data = '0;
  logic [BW-1:0]  hst_be = '0;
  logic           hst_io = 1'b0;
  logic           hst_rdy;
  logic [NS-1:0]  crd_req;
  logic [NS-1:0]  crd_ack = '0;
  logic [NS*AW-1:0] crd_addr;
  logic [NS*DW-1:0] crd_data;
  logic [NS*BW-1:0] crd_be;
  logic [NS-1:0]  crd_io;
  logic [NS-1:0]  empty;

  pwb_buffer_top dut_i (
    .clk_i(clk), .rst_n_i(rst_n),
    .hst_wr_i(hst_wr), .hst_sel_i(hst_sel), .hst_addr_i(hst_addr),
    .hst_data_i(hst_data), .hst_be_i(hst_be), .hst_io_i(hst_io),
    .hst_rdy_o(hst_rdy),
    .crd_req_o(crd_req), .crd_ack_i(crd_ack), .crd_addr_o(crd_addr),
    .crd_data_o(crd_data), .crd_be_o(crd_be), .crd_io_o(crd_io),
    .empty_o(empty)
  );

  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;
  int   mode [NS];
  logic [7:0] lfsr = 8'hA5;
  exp_t q0 [$];
  exp_t q1 [$];
  int   pushed = 0;
  int   popped = 0;
  int   seq = 0;
  bit   hold_v [NS];
  exp_t hold_e [NS];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // one cycle: falling edge, clear strobe, compute acknowledges
  task automatic step();
    @(negedge clk);
    hst_wr = 1'b0;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    for (int s = 0; s < NS; s++)
      crd_ack[s] = (mode[s] == 1) || (mode[s] == 2 && lfsr[s*3]);
  endtask

  function automatic exp_t mk(input int n);
    exp_t e;
    e.a = AW'(16'h1000 + n * 7);
    e.d = DW'(n * 16'h0123) ^ 16'h5A5A;
    e.b = BW'((n % 3) + 1);
    e.i = n[0];
    return e;
  endfunction

  // rel >= 0: enable acknowledge of socket s after rel stalled cycles
  task automatic host_write(input int s, input int rel, output int waits);
    exp_t e;
    bit acc;
    e = mk(seq);
    seq++;
    waits = 0;
    acc = 1'b0;
    while (!acc) begin
      if (rel >= 0 && waits == rel) mode[s] = 1;
      step();
      hst_wr = 1'b1; hst_sel = s[0]; hst_addr = e.a; hst_data = e.d;
      hst_be = e.b; hst_io = e.i;
      #1;
      if (hst_rdy) begin
        acc = 1'b1;
        pushed++;
        if (s == 0) q0.push_back(e); else q1.push_back(e);
      end else begin
        waits++;
      end
    end
  endtask

  // scoreboard monitor: pops expected entries on each drain handshake
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      for (int s = 0; s < NS; s++) begin
        exp_t got;
        exp_t ex;
        got = {crd_addr[s*AW +: AW], crd_data[s*DW +: DW], crd_be[s*BW +: BW], crd_io[s]};
        if (hold_v[s] && crd_req[s])
          check(got == hold_e[s], "R7", "head changed without acknowledge", 64'(got), 64'(hold_e[s]));
        if (crd_req[s] && crd_ack[s]) begin
          popped++;
          if (s == 0 && q0.size() > 0) begin
            ex = q0.pop_front();
            check(got == ex, "R6", "socket 0 drained entry", 64'(got), 64'(ex));
          end else if (s == 1 && q1.size() > 0) begin
            ex = q1.pop_front();
            check(got == ex, "R6", "socket 1 drained entry", 64'(got), 64'(ex));
          end else begin
            check(1'b0, "R7", "request with nothing posted", 64'(got), 64'd0);
          end
        end
        hold_v[s] = crd_req[s] && !crd_ack[s];
        hold_e[s] = got;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int w;
    mode[0] = 0; mode[1] = 0;
    hold_v[0] = 1'b0; hold_v[1] = 1'b0;
    repeat (3) step();
    // R1 during reset
    #1;
    check(empty == 2'b11, "R1", "empty in reset", 64'(empty), 64'h3);
    rst_n = 1'b1;
    repeat (4) step();
    #1;
    check(empty == 2'b11, "R1", "empty after reset", 64'(empty), 64'h3);
    check(crd_req == 2'b00, "R1", "request after reset", 64'(crd_req), 64'h0);
    check(hst_rdy == 1'b1, "R1", "ready after reset", 64'(hst_rdy), 64'h1);

    // R3 / R10: four writes to socket 0, no drain
    for (int k = 0; k < 4; k++) begin
      host_write(0, -1, w);
      check(w == 0, "R3", "wait states with free entry", 64'(w), 64'd0);
    end
    step(); #1;
    check(empty == 2'b10, "R2", "only socket 0 filled", 64'(empty), 64'h2);
    check(crd_req == 2'b01, "R7", "request follows content", 64'(crd_req), 64'h1);

    // R4 / R10: fifth write to socket 0 stalls
    step();
    hst_wr = 1'b1; hst_sel = 1'b0;
    #1;
    check(hst_rdy == 1'b0, "R10", "fifth write ready", 64'(hst_rdy), 64'h0);

    // R9: socket 1 still free while socket 0 full
    host_write(1, -1, w);
    check(w == 0, "R9", "socket 1 waits with socket 0 full", 64'(w), 64'd0);

    // R4: stall until acknowledge enabled after 3 cycles
    host_write(0, 3, w);
    check(w == 3, "R4", "wait states until drain", 64'(w), 64'd3);

    // R8: drain socket 0 to empty
    for (int k = 0; k < 20 && !empty[0]; k++) step();
    step(); #1;
    check(empty[0] == 1'b1, "R8", "socket 0 empty after drain", 64'(empty[0]), 64'h1);
    check(q0.size() == 0, "R6", "socket 0 expected entries left", 64'(q0.size()), 64'd0);

    // R5: refill socket 0, then write while draining in the same cycle
    mode[0] = 0;
    for (int k = 0; k < 4; k++) host_write(0, -1, w);
    host_write(0, 0, w);
    check(w == 0, "R5", "wait states on full with same-cycle drain", 64'(w), 64'd0);

    // R6 / R7: mixed traffic with irregular acknowledges
    mode[0] = 2; mode[1] = 2;
    for (int k = 0; k < 24; k++) host_write(k % 2, -1, w);

    mode[0] = 1; mode[1] = 1;
    for (int k = 0; k < 40 && empty != 2'b11; k++) step();
    step(); #1;
    check(empty == 2'b11, "R8", "both empty at end", 64'(empty), 64'h3);
    check(crd_req == 2'b00, "R7", "no request when empty", 64'(crd_req), 64'h0);
    check(q0.size() + q1.size() == 0, "R6", "entries never drained", 64'(q0.size() + q1.size()), 64'd0);
    check(popped == pushed, "R6", "drained count", 64'(popped), 64'(pushed));

    done = 1'b1;
    summary();
    $finish;
  end
endmodule